// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block keeps every in-flight memory operation in program order inside a small circular queue. A store collects its address and its data value through two independent write ports, in either order. A load collects only its address. Once a load knows its address, the queue scans the entries older than it and finds the nearest one with the same address. If that entry already holds a value, whether it is a store with its data or a load that has returned, the queue forwards the value without touching memory. If that entry has no value yet, the load waits. If any older store still lacks an address, the load also waits, because the queue never guesses. With no match and no unknown store address, the load is sent to memory as a read.

Every load value, forwarded or read, leaves on a single registered result bus tagged with the load's queue index. Stores never reach memory until the reorder buffer commits them. Commits arrive one per cycle in program order. Committed stores are written to memory from the head of the queue, so memory sees them strictly in order. Entries are freed in order from the head. A load leaves once it is committed. A store leaves once its memory write has been accepted.

Top module: `ldst_queue`

## Requirements
- R1: After reset `alloc_ready` is 1, `alloc_idx` is 0, and there is no memory request and no result. Allocation hands out indices 0,1,2,... in order, wrapping after DEPTH-1. `alloc_ready` is 0 while DEPTH entries are occupied.
- R2: A store accepts its address and its data in either order. Its memory write carries both (`mem_req_write`=1, `mem_req_addr`, `mem_req_wdata`).
- R3: A load with a known address that matches no older entry, and has no older store of unknown address, issues exactly one read (`mem_req_write`=0) carrying its address and its index on `mem_req_tag`.
- R4: A read response is broadcast on the result bus, tagged with the load index, in the cycle after the response is presented.
- R5: A load whose nearest older match is a store holding its data receives that data on the result bus and makes no memory read.
- R6: A load whose nearest older match is a store still lacking data produces no read and no result until that data is written. The data is then forwarded.
- R7: A load whose nearest older match is a load that has already broadcast its value receives the same value without a second memory read.
- R8: A load whose nearest older match is a load still waiting for its value produces no read and no result until the older load's value is broadcast.
- R9: While any older store has no address, a load makes no read and gets no result. Once that address is written and does not match, the load proceeds.
- R10: With several older matching stores, the youngest of them (nearest to the load) supplies the value.
- R11: A store writes memory only after it is committed. Stores write memory in commit order. A write that is not accepted (`mem_req_ready`=0) stays on the request port.
- R12: If a memory response and a forward are ready in the same cycle, the response is broadcast first and the forward follows in the next cycle. Neither is lost.
- R13: Entries are freed in order from the head. Once a committed head store's write is accepted, a full queue accepts a new allocation again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new entry at the tail |
| alloc_store | input | 1 | 1: the new entry is a store, 0: a load |
| alloc_ready | output | 1 | The queue has a free entry |
| alloc_idx | output | IW | Index the next allocation receives |
| addr_valid | input | 1 | Address write strobe |
| addr_idx | input | IW | Entry receiving the address |
| addr_value | input | ADDR_W | Address value |
| data_valid | input | 1 | Store data write strobe |
| data_idx | input | IW | Store entry receiving the data |
| data_value | input | DATA_W | Store data value |
| commit_valid | input | 1 | Commit the oldest uncommitted entry |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1: write (store), 0: read (load) |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_req_tag | output | IW | Queue index of the requesting entry |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_tag | input | IW | Tag of the answered read |
| mem_rsp_data | input | DATA_W | Read data |
| res_valid | output | 1 | Load result broadcast |
| res_tag | output | IW | Index of the load being completed |
| res_data | output | DATA_W | Load value |

## Verification
The assertions assume several things about the inputs. Commits come only for an entry that is allocated and not yet committed. A store is committed only after both its address and its data are written, and a load only after its result has appeared on the bus. Every read response names a load that was issued and has not yet returned. The bench meets these rules by committing in allocation order, only after it sees the store fields written or the load's result in its own log. Its memory model answers each accepted read once, one cycle later, with the accepted tag. It allocates only while `alloc_ready` is high.

// File: rtl/ldst_queue_pkg.sv
package ldst_queue_pkg;

   // kind of request presented on the memory port
   typedef enum logic {
      REQ_READ  = 1'b0,
      REQ_WRITE = 1'b1
   } req_kind_e;

endpackage

// File: rtl/ldst_age_search.sv
// Scans the entries older than one load slot, nearest first, and reports
// whether the load may take a forwarded value or go to memory.
module ldst_age_search #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SLOT   = 0
) (
   input  logic [$clog2(DEPTH)-1:0]         head_i,
   input  logic [DEPTH-1:0]                 valid_i,
   input  logic [DEPTH-1:0]                 store_i,
   input  logic [DEPTH-1:0]                 aok_i,
   input  logic [DEPTH-1:0]                 dok_i,
   input  logic [DEPTH-1:0][ADDR_W-1:0]     addr_i,
   input  logic [DEPTH-1:0][DATA_W-1:0]     data_i,
   output logic                             fwd_o,
   output logic [DATA_W-1:0]                fwd_data_o,
   output logic                             mem_o
);
   localparam int IW = $clog2(DEPTH);
   localparam logic [IW-1:0] ME = IW'(SLOT);

   logic [IW-1:0] age;
   logic [IW-1:0] j;
   logic          found;
   logic          blocked;
   logic          hit_ok;

   always_comb begin
      age        = ME - head_i;
      found      = 1'b0;
      blocked    = 1'b0;
      hit_ok     = 1'b0;
      fwd_data_o = '0;
      j          = ME;
      for (int k = 1; k < DEPTH; k++) begin
         j = ME - IW'(k);
         if (k <= int'(age) && valid_i[j]) begin
            if (store_i[j] && !aok_i[j]) begin
               blocked = 1'b1;
            end else if (!found && aok_i[j] && addr_i[j] == addr_i[SLOT]) begin
               found      = 1'b1;
               hit_ok     = dok_i[j];
               fwd_data_o = data_i[j];
            end
         end
      end
      fwd_o = !blocked && found && hit_ok;
      mem_o = !blocked && !found;
   end

endmodule

// File: rtl/ldst_oldest_pick.sv
// Picks the request nearest to the head (the oldest) in a circular queue.
module ldst_oldest_pick #(
   parameter int DEPTH = 8
) (
   input  logic [$clog2(DEPTH)-1:0] head_i,
   input  logic [DEPTH-1:0]         req_i,
   output logic                     valid_o,
   output logic [$clog2(DEPTH)-1:0] idx_o
);
   localparam int IW = $clog2(DEPTH);

   logic [IW-1:0] j;

   always_comb begin
      valid_o = 1'b0;
      idx_o   = head_i;
      j       = head_i;
      for (int k = 0; k < DEPTH; k++) begin
         j = head_i + IW'(k);
         if (!valid_o && req_i[j]) begin
            valid_o = 1'b1;
            idx_o   = j;
         end
      end
   end

endmodule

// File: rtl/ldst_queue.sv
module ldst_queue
   import ldst_queue_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_valid,
   input  logic                       alloc_store,
   output logic                       alloc_ready,
   output logic [$clog2(DEPTH)-1:0]   alloc_idx,
   input  logic                       addr_valid,
   input  logic [$clog2(DEPTH)-1:0]   addr_idx,
   input  logic [ADDR_W-1:0]          addr_value,
   input  logic                       data_valid,
   input  logic [$clog2(DEPTH)-1:0]   data_idx,
   input  logic [DATA_W-1:0]          data_value,
   input  logic                       commit_valid,
   output logic                       mem_req_valid,
   output logic                       mem_req_write,
   output logic [ADDR_W-1:0]          mem_req_addr,
   output logic [DATA_W-1:0]          mem_req_wdata,
   output logic [$clog2(DEPTH)-1:0]   mem_req_tag,
   input  logic                       mem_req_ready,
   input  logic                       mem_rsp_valid,
   input  logic [$clog2(DEPTH)-1:0]   mem_rsp_tag,
   input  logic [DATA_W-1:0]          mem_rsp_data,
   output logic                       res_valid,
   output logic [$clog2(DEPTH)-1:0]   res_tag,
   output logic [DATA_W-1:0]          res_data
);
   localparam int IW = $clog2(DEPTH);
   localparam int CW = IW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   // elaboration-time parameter checks
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("ldst_queue: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ldst_queue: ADDR_W and DATA_W must be positive");
   end

   // per-entry state
   logic [DEPTH-1:0]             v_q;    // occupied
   logic [DEPTH-1:0]             st_q;   // entry is a store
   logic [DEPTH-1:0]             aok_q;  // address known
   logic [DEPTH-1:0]             dok_q;  // value known (store data / load result)
   logic [DEPTH-1:0]             iss_q;  // load sent to memory
   logic [DEPTH-1:0]             cmt_q;  // committed by the reorder buffer
   logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
   logic [DEPTH-1:0][DATA_W-1:0] data_q;

   logic [IW-1:0] head_q, tail_q, cptr_q;
   logic [CW-1:0] cnt_q;

   logic              res_v_q;
   logic [IW-1:0]     res_tag_q;
   logic [DATA_W-1:0] res_data_q;

   // search results for every slot
   logic [DEPTH-1:0]             fwd_ok;
   logic [DEPTH-1:0]             rd_ok;
   logic [DEPTH-1:0][DATA_W-1:0] fwd_data;
   logic [DEPTH-1:0]             need;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      ldst_age_search #(
         .DEPTH (DEPTH),
         .ADDR_W(ADDR_W),
         .DATA_W(DATA_W),
         .SLOT  (g)
      ) u_search (
         .head_i    (head_q),
         .valid_i   (v_q),
         .store_i   (st_q),
         .aok_i     (aok_q),
         .dok_i     (dok_q),
         .addr_i    (addr_q),
         .data_i    (data_q),
         .fwd_o     (fwd_ok[g]),
         .fwd_data_o(fwd_data[g]),
         .mem_o     (rd_ok[g])
      );
      assign need[g] = v_q[g] & ~st_q[g] & aok_q[g] & ~dok_q[g] & ~iss_q[g];
   end

   logic          fwd_pick_v, rd_pick_v;
   logic [IW-1:0] fwd_pick_idx, rd_pick_idx;

   ldst_oldest_pick #(.DEPTH(DEPTH)) u_fwd_pick (
      .head_i (head_q),
      .req_i  (need & fwd_ok),
      .valid_o(fwd_pick_v),
      .idx_o  (fwd_pick_idx)
   );

   ldst_oldest_pick #(.DEPTH(DEPTH)) u_rd_pick (
      .head_i (head_q),
      .req_i  (need & rd_ok),
      .valid_o(rd_pick_v),
      .idx_o  (rd_pick_idx)
   );

   // memory port: a committed store at the head outranks any load read
   logic      head_wr;
   req_kind_e kind;
   logic      wr_fire, rd_fire, head_free, alloc_fire;

   always_comb begin
      head_wr = v_q[head_q] & st_q[head_q] & cmt_q[head_q];
      kind    = head_wr ? REQ_WRITE : REQ_READ;
   end

   assign mem_req_valid = head_wr | rd_pick_v;
   assign mem_req_write = (kind == REQ_WRITE);
   assign mem_req_addr  = head_wr ? addr_q[head_q] : addr_q[rd_pick_idx];
   assign mem_req_wdata = data_q[head_q];
   assign mem_req_tag   = head_wr ? head_q : rd_pick_idx;

   assign wr_fire    = head_wr & mem_req_ready;
   assign rd_fire    = ~head_wr & rd_pick_v & mem_req_ready;
   assign head_free  = v_q[head_q] & cmt_q[head_q] & (~st_q[head_q] | wr_fire);
   assign alloc_ready = (cnt_q != FULL_CNT);
   assign alloc_fire  = alloc_valid & alloc_ready;
   assign alloc_idx   = tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q        <= '0;
         st_q       <= '0;
         aok_q      <= '0;
         dok_q      <= '0;
         iss_q      <= '0;
         cmt_q      <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         head_q     <= '0;
         tail_q     <= '0;
         cptr_q     <= '0;
         cnt_q      <= '0;
         res_v_q    <= 1'b0;
         res_tag_q  <= '0;
         res_data_q <= '0;
      end else begin
         if (head_free) begin
            v_q[head_q]   <= 1'b0;
            cmt_q[head_q] <= 1'b0;
            head_q        <= head_q + 1'b1;
         end
         if (alloc_fire) begin
            v_q[tail_q]   <= 1'b1;
            st_q[tail_q]  <= alloc_store;
            aok_q[tail_q] <= 1'b0;
            dok_q[tail_q] <= 1'b0;
            iss_q[tail_q] <= 1'b0;
            cmt_q[tail_q] <= 1'b0;
            tail_q        <= tail_q + 1'b1;
         end
         cnt_q <= cnt_q + CW'(alloc_fire) - CW'(head_free);
         if (addr_valid) begin
            aok_q[addr_idx]  <= 1'b1;
            addr_q[addr_idx] <= addr_value;
         end
         if (data_valid) begin
            dok_q[data_idx]  <= 1'b1;
            data_q[data_idx] <= data_value;
         end
         if (rd_fire) begin
            iss_q[rd_pick_idx] <= 1'b1;
         end
         if (commit_valid) begin
            cmt_q[cptr_q] <= 1'b1;
            cptr_q        <= cptr_q + 1'b1;
         end
         // result bus: memory response first, forwarding otherwise
         if (mem_rsp_valid) begin
            res_v_q              <= 1'b1;
            res_tag_q            <= mem_rsp_tag;
            res_data_q           <= mem_rsp_data;
            dok_q[mem_rsp_tag]   <= 1'b1;
            data_q[mem_rsp_tag]  <= mem_rsp_data;
         end else if (fwd_pick_v) begin
            res_v_q              <= 1'b1;
            res_tag_q            <= fwd_pick_idx;
            res_data_q           <= fwd_data[fwd_pick_idx];
            dok_q[fwd_pick_idx]  <= 1'b1;
            data_q[fwd_pick_idx] <= fwd_data[fwd_pick_idx];
         end else begin
            res_v_q <= 1'b0;
         end
      end
   end

   assign res_valid = res_v_q;
   assign res_tag   = res_tag_q;
   assign res_data  = res_data_q;

   // occupancy never exceeds the storage (R1)
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

   // a store write only leaves with both fields filled (R2, R11)
   a_r11_write_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> (aok_q[head_q] && dok_q[head_q]));

   // a load is read from memory at most once (R3)
   a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> !iss_q[mem_req_tag]);

   // responses only answer loads that are in flight (R4)
   a_r4_rsp_matches_issue: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (v_q[mem_rsp_tag] && iss_q[mem_rsp_tag] && !dok_q[mem_rsp_tag]));

   // broadcasts name an occupied load entry (R7)
   a_r7_result_is_load: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (v_q[res_tag] && !st_q[res_tag]));

   // commits walk live, uncommitted entries in order (R13)
   a_r13_commit_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |-> (v_q[cptr_q] && !cmt_q[cptr_q]));

endmodule

// File: tb/ldst_queue_test.sv
module ldst_queue_test;
   localparam int DEPTH = 8;
   localparam int IW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_valid = 1'b0, alloc_store = 1'b0;
   logic          alloc_ready;
   logic [IW-1:0] alloc_idx;
   logic          addr_valid = 1'b0;
   logic [IW-1:0] addr_idx = '0;
   logic [15:0]   addr_value = '0;
   logic          data_valid = 1'b0;
   logic [IW-1:0] data_idx = '0;
   logic [31:0]   data_value = '0;
   logic          commit_valid = 1'b0;
   logic          mem_req_valid, mem_req_write;
   logic [15:0]   mem_req_addr;
   logic [31:0]   mem_req_wdata;
   logic [IW-1:0] mem_req_tag;
   logic          mem_req_ready = 1'b1;
   logic          mem_rsp_valid = 1'b0;
   logic [IW-1:0] mem_rsp_tag = '0;
   logic [31:0]   mem_rsp_data = '0;
   logic          res_valid;
   logic [IW-1:0] res_tag;
   logic [31:0]   res_data;

   always #4 clk = ~clk;   // 125 MHz

   ldst_queue #(.DEPTH(DEPTH), .ADDR_W(16), .DATA_W(32)) uut (.*);

   int checks = 0;
   int errors = 0;
   int exp_tail = 0;

   // memory model and logs
   logic [31:0] mem [16];
   int cyc = 0;
   logic          pend_v = 1'b0;
   logic [IW-1:0] pend_tag = '0;
   logic [31:0]   pend_data = '0;
   int n_rd = 0, n_wr = 0, n_res = 0;
   int rd_tag [64]; int rd_addr [64]; int rd_cyc [64];
   int wr_addr [64]; logic [31:0] wr_data [64];
   int res_t [64]; logic [31:0] res_d [64]; int res_c [64];

   function automatic logic [31:0] mem_init(int a);
      return 32'hA000_0000 | 32'(a);
   endfunction

   initial for (int a = 0; a < 16; a++) mem[a] = mem_init(a);

   always begin
      @(negedge clk); #1;
      cyc++;
      mem_rsp_valid = pend_v;
      mem_rsp_tag   = pend_tag;
      mem_rsp_data  = pend_data;
      pend_v        = 1'b0;
      if (rst_n && res_valid && n_res < 64) begin
         res_t[n_res] = int'(res_tag); res_d[n_res] = res_data; res_c[n_res] = cyc;
         n_res++;
      end
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            mem[mem_req_addr[3:0]] = mem_req_wdata;
            if (n_wr < 64) begin
               wr_addr[n_wr] = int'(mem_req_addr); wr_data[n_wr] = mem_req_wdata; n_wr++;
            end
         end else begin
            pend_v    = 1'b1;
            pend_tag  = mem_req_tag;
            pend_data = mem[mem_req_addr[3:0]];
            if (n_rd < 64) begin
               rd_tag[n_rd] = int'(mem_req_tag); rd_addr[n_rd] = int'(mem_req_addr);
               rd_cyc[n_rd] = cyc; n_rd++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   function automatic int find_res(input int tag, input int from);
      for (int i = from; i < n_res; i++) if (res_t[i] == tag) return i;
      return -1;
   endfunction

   task automatic alloc(input bit st, output logic [IW-1:0] idx);
      chk(alloc_ready == 1'b1, "R1", "alloc_ready before allocation", 64'(alloc_ready), 64'd1);
      chk(alloc_idx == IW'(exp_tail), "R1", "allocated index", 64'(alloc_idx), 64'(exp_tail % DEPTH));
      idx = alloc_idx;
      alloc_valid = 1'b1; alloc_store = st;
      tick();
      alloc_valid = 1'b0;
      exp_tail = (exp_tail + 1) % DEPTH;
   endtask

   task automatic set_addr(input logic [IW-1:0] i, input int a);
      addr_valid = 1'b1; addr_idx = i; addr_value = 16'(a);
      tick();
      addr_valid = 1'b0;
   endtask

   task automatic set_data(input logic [IW-1:0] i, input logic [31:0] d);
      data_valid = 1'b1; data_idx = i; data_value = d;
      tick();
      data_valid = 1'b0;
   endtask

   task automatic do_commit();
      commit_valid = 1'b1;
      tick();
      commit_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk(alloc_ready == 1'b1, "R1", "reset alloc_ready", 64'(alloc_ready), 64'd1);
      chk(alloc_idx == '0, "R1", "reset alloc_idx", 64'(alloc_idx), 64'd0);
      chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk(res_valid == 1'b0, "R1", "reset res_valid", 64'(res_valid), 64'd0);
   endtask

   task automatic t_mem_read();
      logic [IW-1:0] l;
      int r0 = n_rd, s0 = n_res, k;
      alloc(1'b0, l);
      set_addr(l, 3);
      tick(6);
      chk(n_rd == r0 + 1, "R3", "read count", 64'(n_rd - r0), 64'd1);
      chk(rd_addr[r0] == 3 && rd_tag[r0] == int'(l), "R3", "read addr/tag",
          64'(rd_addr[r0]), 64'd3);
      k = find_res(int'(l), s0);
      chk(k >= 0 && res_d[k] == mem_init(3), "R4", "read result data",
          (k >= 0) ? 64'(res_d[k]) : 64'hDEAD, 64'(mem_init(3)));
      chk(k >= 0 && res_c[k] == rd_cyc[r0] + 2, "R4", "result cycle after accept",
          (k >= 0) ? 64'(res_c[k] - rd_cyc[r0]) : 64'hDEAD, 64'd2);
      do_commit();
      tick(2);
   endtask

   task automatic t_store_fwd();
      logic [IW-1:0] s, l, s2;
      int r0 = n_rd, s0 = n_res, w0 = n_wr, k;
      alloc(1'b1, s);
      alloc(1'b0, l);
      set_addr(s, 5);
      set_addr(l, 5);
      tick(4);
      chk(find_res(int'(l), s0) < 0 && n_rd == r0, "R6", "load waits for store data",
          64'(n_res - s0), 64'd0);
      set_data(s, 32'h1111_5555);
      tick(4);
      k = find_res(int'(l), s0);
      chk(k >= 0 && res_d[k] == 32'h1111_5555, "R5", "forwarded store data",
          (k >= 0) ? 64'(res_d[k]) : 64'hDEAD, 64'h1111_5555);
      chk(n_rd == r0, "R5", "no memory read when forwarding", 64'(n_rd - r0), 64'd0);
      chk(n_wr == w0, "R11", "no write before commit", 64'(n_wr - w0), 64'd0);
      do_commit();
      do_commit();
      tick(4);
      chk(n_wr == w0 + 1 && wr_addr[w0] == 5 && wr_data[w0] == 32'h1111_5555, "R2",
          "address-first store write", 64'(wr_data[w0]), 64'h1111_5555);
      alloc(1'b1, s2);
      set_data(s2, 32'h2222_6666);
      set_addr(s2, 6);
      do_commit();
      tick(4);
      chk(n_wr == w0 + 2 && wr_addr[w0+1] == 6 && wr_data[w0+1] == 32'h2222_6666, "R2",
          "data-first store write", 64'(wr_data[w0+1]), 64'h2222_6666);
   endtask

   task automatic t_unknown_store();
      logic [IW-1:0] s, l;
      int r0 = n_rd, s0 = n_res, k;
      alloc(1'b1, s);
      alloc(1'b0, l);
      set_addr(l, 7);
      tick(5);
      chk(n_rd == r0 && n_res == s0, "R9", "load held by unknown store address",
          64'(n_rd - r0), 64'd0);
      set_addr(s, 8);
      tick(6);
      chk(n_rd == r0 + 1 && rd_addr[r0] == 7, "R9", "load released after address",
          64'(n_rd - r0), 64'd1);
      k = find_res(int'(l), s0);
      chk(k >= 0 && res_d[k] == mem_init(7), "R9", "released load data",
          (k >= 0) ? 64'(res_d[k]) : 64'hDEAD, 64'(mem_init(7)));
      set_data(s, 32'h3333_8888);
      do_commit();
      do_commit();
      tick(4);
   endtask

   task automatic t_load_chain();
      logic [IW-1:0] l1, l2;
      int r0 = n_rd, s0 = n_res, k1, k2;
      mem_req_ready = 1'b0;
      alloc(1'b0, l1);
      alloc(1'b0, l2);
      set_addr(l1, 9);
      set_addr(l2, 9);
      tick(4);
      chk(n_rd == r0 && n_res == s0, "R8", "younger load waits on pending older load",
          64'(n_res - s0), 64'd0);
      mem_req_ready = 1'b1;
      tick(8);
      chk(n_rd == r0 + 1, "R7", "single read for two same-address loads",
          64'(n_rd - r0), 64'd1);
      k1 = find_res(int'(l1), s0);
      k2 = find_res(int'(l2), s0);
      chk(k2 >= 0 && res_d[k2] == mem_init(9), "R7", "forwarded load value",
          (k2 >= 0) ? 64'(res_d[k2]) : 64'hDEAD, 64'(mem_init(9)));
      chk(k1 >= 0 && k2 > k1, "R8", "younger result after older", 64'(k2), 64'(k1 + 1));
      do_commit();
      do_commit();
      tick(2);
   endtask

   task automatic t_nearest();
      logic [IW-1:0] s1, s2, l;
      int s0 = n_res, w0 = n_wr, k;
      alloc(1'b1, s1);
      alloc(1'b1, s2);
      alloc(1'b0, l);
      set_addr(s1, 4);
      set_data(s1, 32'h0000_AAAA);
      set_addr(s2, 4);
      set_data(s2, 32'h0000_BBBB);
      set_addr(l, 4);
      tick(4);
      k = find_res(int'(l), s0);
      chk(k >= 0 && res_d[k] == 32'h0000_BBBB, "R10", "nearest store wins",
          (k >= 0) ? 64'(res_d[k]) : 64'hDEAD, 64'h0000_BBBB);
      do_commit();
      do_commit();
      do_commit();
      tick(4);
      chk(n_wr == w0 + 2 && wr_data[w0] == 32'h0000_AAAA && wr_data[w0+1] == 32'h0000_BBBB,
          "R11", "writes in commit order", 64'(wr_data[w0]), 64'h0000_AAAA);
   endtask

   task automatic t_hold();
      logic [IW-1:0] s;
      int w0 = n_wr;
      mem_req_ready = 1'b0;
      alloc(1'b1, s);
      set_addr(s, 13);
      set_data(s, 32'hCAFE_0013);
      do_commit();
      tick(4);
      chk(n_wr == w0 && mem_req_valid && mem_req_write && mem_req_wdata == 32'hCAFE_0013,
          "R11", "refused write stays on port", 64'(mem_req_wdata), 64'hCAFE_0013);
      mem_req_ready = 1'b1;
      tick(3);
      chk(n_wr == w0 + 1 && wr_addr[w0] == 13, "R11", "write after ready", 64'(n_wr - w0), 64'd1);
   endtask

   task automatic t_collide();
      logic [IW-1:0] s, b, a;
      int s0 = n_res, ka, kb;
      mem_req_ready = 1'b0;
      alloc(1'b1, s);
      alloc(1'b0, b);
      alloc(1'b0, a);
      set_addr(s, 11);
      set_addr(b, 11);
      set_addr(a, 10);
      tick(3);
      chk(n_res == s0, "R12", "nothing broadcast before release", 64'(n_res - s0), 64'd0);
      mem_req_ready = 1'b1;
      data_valid = 1'b1; data_idx = s; data_value = 32'h5150_0011;
      tick();
      data_valid = 1'b0;
      tick(6);
      ka = find_res(int'(a), s0);
      kb = find_res(int'(b), s0);
      chk(ka >= 0 && res_d[ka] == mem_init(10), "R12", "response result",
          (ka >= 0) ? 64'(res_d[ka]) : 64'hDEAD, 64'(mem_init(10)));
      chk(kb >= 0 && res_d[kb] == 32'h5150_0011, "R12", "forward result",
          (kb >= 0) ? 64'(res_d[kb]) : 64'hDEAD, 64'h5150_0011);
      chk(ka >= 0 && kb >= 0 && res_c[kb] == res_c[ka] + 1, "R12", "forward one cycle after response",
          (ka >= 0 && kb >= 0) ? 64'(res_c[kb] - res_c[ka]) : 64'hDEAD, 64'd1);
      do_commit();
      do_commit();
      do_commit();
      tick(4);
   endtask

   task automatic t_full();
      logic [IW-1:0] idx [DEPTH];
      logic [IW-1:0] extra;
      int w0 = n_wr;
      for (int i = 0; i < DEPTH; i++) begin
         alloc(1'b1, idx[i]);
         set_addr(idx[i], 12);
         set_data(idx[i], 32'h7700_0000 | 32'(i));
      end
      chk(alloc_ready == 1'b0, "R1", "full queue refuses allocation", 64'(alloc_ready), 64'd0);
      do_commit();
      tick(3);
      chk(alloc_ready == 1'b1, "R13", "head freed after write", 64'(alloc_ready), 64'd1);
      alloc(1'b1, extra);
      set_addr(extra, 14);
      set_data(extra, 32'h7700_00FF);
      for (int i = 1; i <= DEPTH; i++) do_commit();
      tick(6);
      chk(n_wr == w0 + DEPTH + 1, "R13", "all stores written", 64'(n_wr - w0), 64'(DEPTH + 1));
      for (int i = 0; i < DEPTH; i++)
         chk(wr_data[w0+i] == (32'h7700_0000 | 32'(i)), "R13", "in-order write",
             64'(wr_data[w0+i]), 64'(32'h7700_0000 | 32'(i)));
      chk(wr_data[w0+DEPTH] == 32'h7700_00FF, "R13", "wrapped entry write",
          64'(wr_data[w0+DEPTH]), 64'h7700_00FF);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mem_read();
      t_store_fwd();
      t_unknown_store();
      t_load_chain();
      t_nearest();
      t_hold();
      t_collide();
      t_full();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule